// File: doc/BRIEF.md
# Touch Digitizer Serial Front End

This block models the digital side of a touch-screen converter that acts as a serial slave. A host lowers chip select and clocks the serial line. The block waits for a 1 on the data input, which marks the start of a frame. It then collects a control byte one bit per rising serial edge. Every other point in the frame is timed by counting falling serial edges from the start bit. At the hold point the block raises BUSY for one serial period and captures a 12-bit sample from a parallel input. It then shifts that sample out MSB first and pads the frame with zeros.

A two-bit power code sits in the two least significant control bits. The code sets three things: whether the core sleeps between conversions, whether the pen interrupt is enabled, and whether the Y-minus switch closes while the core sleeps. A new code is held back until the conversion that carried it has finished. The `coreActive` output lets the duty of the powered state be measured. The serial clock is sampled by the fast system clock, and every action happens on the system clock edge that detects a serial edge.

Top module: `digitizer_serial_slave`

## Requirements
- R1: While `csN` is high, `outEn` is 0 and `dout` and `busy` read 0. Serial edges seen during that time start no frame, even with `din` at 1.
- R2: While no frame is open, 0s sampled on rising `dclk` edges are skipped. The first 1 sampled with `csN` low opens a frame, and falling edges are counted from 1 after it.
- R3: `busy` goes high after falling edge 8 and goes low after falling edge 9.
- R4: The sample is captured at falling edge 8. Falling edges 9 to 20 put sample bits 11 down to 0 on `dout`, one bit per edge, so a later change of `sample` has no effect.
- R5: `dout` is 0 after falling edges 21 to 24. The frame closes at edge 24.
- R6: In codes 00 and 01, `coreActive` rises at falling edge 4 and drops at falling edge 20, which keeps the core up for 16 serial periods.
- R7: In codes 10 and 11, `coreActive` stays high.
- R8: The power code is taken from control bits [1:0], which come after the start bit (MSB) in each control byte. A new code takes effect only at falling edge 20 of its own frame. Until then the previous code governs `coreActive`, `penIrqEn` and `yMinusOn`.
- R9: `penIrqEn` is the inverse of bit 0 of the active code.
- R10: `yMinusOn` is 1 only when the active code is 00 and the core is down.
- R11: After reset, the code is 00, `coreActive` is 0, `penIrqEn` and `yMinusOn` are 1, and `busy` is 0.
- R12: Raising `csN` in the middle of a frame abandons that frame and keeps the current code. The next start bit begins a fresh count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| dclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data into the block |
| sample | input | 12 | Parallel conversion result |
| dout | output | 1 | Serial result bit, 0 when not driven |
| busy | output | 1 | Hold-phase indicator, 0 when not driven |
| outEn | output | 1 | Drive enable for the `dout` and `busy` pads |
| penIrqEn | output | 1 | Pen interrupt enable |
| yMinusOn | output | 1 | Y-minus switch closed |
| coreActive | output | 1 | Converter core powered |

## Verification
Most internal errors in this block show up as a misplaced falling-edge count. A count that is off shifts where `busy` pulses and where the sample bits land on `dout`. It also moves the `coreActive` edges away from falling edges 4 and 20, and all of these appear within the same frame. A power code taken too early shows on `coreActive`, `penIrqEn` or `yMinusOn` before falling edge 20 instead of at it. A code lost after an abandoned frame shows on the next frame. The bench records the expected pin values after every falling edge, so such errors are caught at the edge where they first appear.

// File: rtl/digi_pkg.sv
package digi_pkg;
  // Strobes from the frame sequencer to the datapath, each one system clock wide.
  typedef struct packed {
    logic startFrame;
    logic ctrlShift;
    logic ctrlLast;
    logic powerUp;
    logic holdStart;
    logic fallAny;
    logic shiftOut;
    logic convEnd;
    logic abortFrame;
  } strobe_t;
endpackage

// File: rtl/digi_ctrl.sv
module digi_ctrl
  import digi_pkg::*;
#(
  parameter int CTRL_W     = 8,
  parameter int SAMPLE_W   = 12,
  parameter int TRAIL_CLKS = 4,
  parameter int PWRUP_FALL = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    dclk,
  input  logic    din,
  output strobe_t st
);
  localparam int FRAME_LEN = CTRL_W + SAMPLE_W + TRAIL_CLKS;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] PWR_N   = CNT_W'(PWRUP_FALL);
  localparam logic [CNT_W-1:0] HOLD_N  = CNT_W'(CTRL_W);
  localparam logic [CNT_W-1:0] LASTC_N = CNT_W'(CTRL_W - 1);
  localparam logic [CNT_W-1:0] END_N   = CNT_W'(CTRL_W + SAMPLE_W);
  localparam logic [CNT_W-1:0] FRAME_N = CNT_W'(FRAME_LEN);

  logic             dclkQ;
  logic             inFrame;
  logic [CNT_W-1:0] fallCnt;
  logic [CNT_W-1:0] nextFall;
  logic             riseEdge, fallEdge, frameFall;

  assign riseEdge  = dclk & ~dclkQ;
  assign fallEdge  = ~dclk & dclkQ;
  assign nextFall  = fallCnt + CNT_W'(1);
  assign frameFall = fallEdge & ~csN & inFrame;

  always_comb begin
    st            = '0;
    st.abortFrame = csN & inFrame;
    st.startFrame = riseEdge & ~csN & ~inFrame & din;
    st.ctrlShift  = riseEdge & ~csN & inFrame & (fallCnt != '0) & (fallCnt <= LASTC_N);
    st.ctrlLast   = st.ctrlShift & (fallCnt == LASTC_N);
    st.fallAny    = fallEdge;
    st.powerUp    = frameFall & (nextFall == PWR_N);
    st.holdStart  = frameFall & (nextFall == HOLD_N);
    st.shiftOut   = frameFall & (nextFall > HOLD_N);
    st.convEnd    = frameFall & (nextFall == END_N);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dclkQ   <= 1'b0;
      inFrame <= 1'b0;
      fallCnt <= '0;
    end else begin
      dclkQ <= dclk;
      if (csN) begin
        inFrame <= 1'b0;
      end else if (st.startFrame) begin
        inFrame <= 1'b1;
        fallCnt <= '0;
      end else if (frameFall) begin
        fallCnt <= nextFall;
        if (nextFall == FRAME_N) inFrame <= 1'b0;
      end
    end
  end

  // R12: a high chip select closes any open frame by the next cycle
  assert_abort_closes_R12: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !inFrame);

  // R5: an open frame never counts past its last falling edge
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    inFrame |-> (fallCnt < FRAME_N));
endmodule

// File: rtl/digi_dp.sv
module digi_dp
  import digi_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  input  logic                din,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                doutQ,
  output logic                busyQ,
  output logic                activeQ,
  output logic [1:0]          pdCode
);
  logic                prevBit;
  logic [1:0]          pdPending;
  logic [SAMPLE_W-1:0] outSr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevBit   <= 1'b0;
      pdPending <= 2'b00;
      pdCode    <= 2'b00;
      activeQ   <= 1'b0;
      busyQ     <= 1'b0;
      doutQ     <= 1'b0;
      outSr     <= '0;
    end else begin
      if (st.ctrlShift) prevBit <= din;
      if (st.ctrlLast) pdPending <= {prevBit, din};

      if (st.holdStart) busyQ <= 1'b1;
      else if (st.fallAny || st.abortFrame) busyQ <= 1'b0;

      if (st.startFrame) doutQ <= 1'b0;
      if (st.holdStart) begin
        outSr <= sample;
      end else if (st.shiftOut) begin
        doutQ <= outSr[SAMPLE_W-1];
        outSr <= {outSr[SAMPLE_W-2:0], 1'b0};
      end

      if (st.powerUp) activeQ <= 1'b1;
      else if (st.convEnd) activeQ <= pdPending[1];
      if (st.convEnd) pdCode <= pdPending;
    end
  end

  // R6: the core only wakes on the power-up falling edge
  assert_wake_on_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(activeQ) |-> $past(st.powerUp));

  // R8: the applied power code only moves at the end of a conversion
  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !st.convEnd |=> $stable(pdCode));

  // R3: busy only rises at the hold point
  assert_busy_at_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(st.holdStart));
endmodule

// File: rtl/digitizer_serial_slave.sv
module digitizer_serial_slave
  import digi_pkg::*;
#(
  parameter int CTRL_W     = 8,
  parameter int SAMPLE_W   = 12,
  parameter int TRAIL_CLKS = 4,
  parameter int PWRUP_FALL = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                dclk,
  input  logic                din,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                dout,
  output logic                busy,
  output logic                outEn,
  output logic                penIrqEn,
  output logic                yMinusOn,
  output logic                coreActive
);
  strobe_t    stb;
  logic       doutQ, busyQ, activeQ;
  logic [1:0] pdCode;

  digi_ctrl #(
    .CTRL_W(CTRL_W), .SAMPLE_W(SAMPLE_W),
    .TRAIL_CLKS(TRAIL_CLKS), .PWRUP_FALL(PWRUP_FALL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .dclk(dclk), .din(din), .st(stb)
  );

  digi_dp #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(stb), .din(din), .sample(sample),
    .doutQ(doutQ), .busyQ(busyQ), .activeQ(activeQ), .pdCode(pdCode)
  );

  assign outEn      = ~csN;
  assign dout       = outEn & doutQ;
  assign busy       = outEn & busyQ;
  assign coreActive = activeQ;
  assign penIrqEn   = ~pdCode[0];
  assign yMinusOn   = ~activeQ & (pdCode == 2'b00);

  // R7: an always-on code never leaves the core down
  assert_always_on_R7: assert property (@(posedge clk) disable iff (!rstN)
    pdCode[1] |-> coreActive);

  // R9: the pen interrupt enable changes only when a conversion ends
  assert_pen_moves_at_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(penIrqEn) |-> $past(stb.convEnd));
endmodule

// File: tb/digitizer_serial_slave_test.sv
module digitizer_serial_slave_test;
  localparam int HALF = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, csN, dclk, din;
  logic [11:0] sample;
  logic        dout, busy, outEn, penIrqEn, yMinusOn, coreActive;

  digitizer_serial_slave uut (
    .clk(clk), .rstN(rstN), .csN(csN), .dclk(dclk), .din(din), .sample(sample),
    .dout(dout), .busy(busy), .outEn(outEn), .penIrqEn(penIrqEn),
    .yMinusOn(yMinusOn), .coreActive(coreActive)
  );

  typedef struct {
    int    n;
    logic  eDout, eBusy, eAct, ePen, eYmin;
    string tag;
  } exp_t;
  exp_t expQ[$];

  int    checks = 0, fails = 0;
  bit    done = 0;
  string curTag = "R11";

  // requirement-level model of the frame
  bit         mIn = 0;
  int         mN = 0;
  logic [1:0] mCode = 2'b00, mPend = 2'b00;
  logic       mPrev = 0, mAct = 0, mBusy = 0, mDout = 0;
  logic [11:0] mSh = '0;

  task automatic check(input string tag, input string what, input int n,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s fall=%0d got %0b expected %0b", tag, what, n, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    exp_t e;
    din = b;
    repeat (HALF) @(negedge clk);
    dclk = 1'b1;
    if (csN) mIn = 0;
    else if (!mIn && b) begin mIn = 1; mN = 0; mDout = 0; end
    else if (mIn && mN >= 1 && mN <= 7) begin
      if (mN == 7) mPend = {mPrev, b};
      mPrev = b;
    end
    repeat (HALF) @(negedge clk);
    mBusy = 0;
    if (csN) mIn = 0;
    else if (mIn) begin
      mN++;
      if (mN == 4) mAct = 1;
      if (mN == 8) begin mBusy = 1; mSh = sample; end
      if (mN >= 9) begin mDout = mSh[11]; mSh = {mSh[10:0], 1'b0}; end
      if (mN == 20) begin mCode = mPend; mAct = mPend[1]; end
      if (mN == 24) mIn = 0;
    end
    e.n = mN; e.eDout = !csN & mDout; e.eBusy = !csN & mBusy; e.eAct = mAct;
    e.ePen = !mCode[0]; e.eYmin = (mCode == 2'b00) && !mAct; e.tag = curTag;
    expQ.push_back(e);
    dclk = 1'b0;
  endtask

  task automatic csHigh();
    csN = 1'b1; mIn = 0; mBusy = 0;
    repeat (4) @(negedge clk);
  endtask

  // lead zeros, start bit, seven control bits ending in the code, then 16 more clocks
  task automatic frame(input int lead, input logic [1:0] code, input logic [11:0] smp,
                       input string tag, input int stopAt, input bit flip);
    logic [6:0] body;
    body = {5'b10110, code};
    curTag = tag; sample = smp;
    csN = 1'b0; repeat (2) @(negedge clk);
    for (int i = 0; i < lead; i++) pulse(1'b0);
    pulse(1'b1);
    for (int k = 2; k <= 24 && k <= stopAt; k++) begin
      if (flip && k == 10) sample = ~smp;
      pulse(k <= 8 ? body[8-k] : 1'b0);
    end
    repeat (3) @(negedge clk);
    csHigh();
  endtask

  // monitor: after each falling serial edge, compare the pins with the oldest item
  initial begin
    wait (rstN === 1'b1);
    forever begin
      exp_t e;
      @(negedge dclk);
      repeat (2) @(negedge clk);
      if (expQ.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected edge got item expected none");
      end else begin
        e = expQ.pop_front();
        check(e.tag == "R1" ? "R1" : (e.n > 20 ? "R5" : "R4"), "dout", e.n, dout, e.eDout);
        check(e.tag == "R1" ? "R1" : "R3", "busy", e.n, busy, e.eBusy);
        check(e.tag, "coreActive", e.n, coreActive, e.eAct);
        check("R9", "penIrqEn", e.n, penIrqEn, e.ePen);
        check("R10", "yMinusOn", e.n, yMinusOn, e.eYmin);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; dclk = 1'b0; din = 1'b0; sample = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11", "coreActive", 0, coreActive, 1'b0);
    check("R11", "penIrqEn", 0, penIrqEn, 1'b1);
    check("R11", "yMinusOn", 0, yMinusOn, 1'b1);
    check("R11", "busy", 0, busy, 1'b0);
    check("R1", "outEn", 0, outEn, 1'b0);
    // R1: serial edges with chip select high are ignored
    curTag = "R1";
    for (int i = 0; i < 3; i++) pulse(1'b1);
    repeat (3) @(negedge clk);
    check("R1", "outEn", 0, outEn, 1'b0);
    // R2 leading zeros, code 00
    frame(2, 2'b00, 12'hA5C, "R2", 24, 0);
    check("R1", "outEn", 0, outEn, 1'b0);
    // R6 code 01 sleeps between conversions
    frame(0, 2'b01, 12'h3F0, "R6", 24, 0);
    // R8 code 10 applied only at the end of its own frame
    frame(1, 2'b10, 12'h801, "R8", 24, 0);
    // R7 always on
    frame(0, 2'b11, 12'h001, "R7", 24, 0);
    // R8 back to 00 from 11
    frame(0, 2'b00, 12'hFFF, "R8", 24, 0);
    // R12 abandoned frame carrying code 10
    frame(0, 2'b10, 12'h5A5, "R12", 10, 0);
    // R4 sample changes after capture
    frame(3, 2'b00, 12'hC36, "R4", 24, 1);
    repeat (5) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2 pending items got %0d expected 0", expQ.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule